// File: doc/BRIEF.md
# Timer Channel Capture/Compare Status Flags

This block is one channel of a 16-bit free-running timer. The channel has a counter that advances on every clock and four general registers. Each general register is set by its own mode bit to work either as a capture register or as a compare register. A status register collects one event flag for each general register and one flag for counter wrap-around. Hardware sets a flag when a capture happens, when a compare match happens, or when the counter wraps. Software on a simple register bus clears a flag with a two-step handshake. First it reads the status register and sees the flag at 1. Then it writes 0 to that flag.

A PWM-mode enable changes two of the registers. The first register (index 0) can no longer raise its flag. The last register (index NGR-1) becomes the period register: a match on it raises its flag, and the counter restarts at zero on the next clock. The last register can also be loaded by a compare-match trigger that comes from another timer channel. This trigger copies the counter into the register but never raises a flag. A level interrupt request is the OR of all flags.

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset, every flag is 0, `irq` is 0, the counter is 0 and every general register is 0.
- R2: The counter goes up by one on every clock. A bus write to address 1 loads the written value, and counting continues from that value on the following clocks. A bus read of address 1 returns the counter.
- R3: When the counter steps from 16'hFFFF to 16'h0000 by counting, status bit NGR (bit 4) reads 1 from the next cycle on.
- R4: While mode bit i of `gr_cmp_mode` is 0 (capture), a pulse on `cap_strobe[i]` stores the counter value of that cycle into general register i and sets status bit i. Register i is at bus address 2+i.
- R5: While mode bit i is 1 (compare), the cycle in which the counter equals register i sets status bit i. The bit reads 1 from the next cycle.
- R6: While mode bit i is 1, `cap_strobe[i]` is ignored: register i keeps its value and no flag is set.
- R7: The status register is at address 0. A flag clears only when 0 is written to it after a status read that returned it as 1. Any status write uses up that read. Writing 1 to a flag has no effect.
- R8: If a hardware set event and a clearing write to the same flag fall in the same cycle, the flag stays 1.
- R9: While `pwm_en` is 1, status bit 0 is never set, by either a capture or a compare.
- R10: While `pwm_en` is 1, the last register acts as a compare register whatever its mode bit. When the counter equals it, its status bit sets and the counter reads 0 on the next cycle.
- R11: While the last register is in capture mode and `pwm_en` is 0, `xch_trig` copies the counter into it and does not set its flag.
- R12: `irq` equals the OR of all status flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Register address: 0 status, 1 counter, 2+i general register i |
| bus_rd | input | 1 | Read strobe; a read of the status register records which flags were seen at 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for `bus_addr`, combinational |
| gr_cmp_mode | input | NGR | Per-register mode: 1 compare, 0 capture |
| cap_strobe | input | NGR | Per-register external capture pulse |
| xch_trig | input | 1 | Capture trigger from another channel's compare match, for the last register |
| pwm_en | input | 1 | PWM mode enable |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can land on one flag in the same cycle: a hardware set event and the software clearing write. The bench arms the clear with a status read. It then drives the clearing write of 0 in the same cycle as a new capture strobe on that register. It judges the result by reading the status over the bus afterwards: the flag must still be 1. A normal read and clear that follows must then bring it to 0. The period match in PWM mode is a second coincidence, because there the flag setting and the counter reload come from one event. The bench samples both the flag and the counter in the match cycle and in the cycle after it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_STAT = 0;
  localparam int unsigned ADDR_CNT  = 1;
  localparam int unsigned ADDR_GR0  = 2;

  typedef enum logic {
    MODE_CAPTURE = 1'b0,
    MODE_COMPARE = 1'b1
  } gr_mode_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_val,
  input  logic          reload,
  output logic [CW-1:0] cnt,
  output logic          wrap_evt
);
  function automatic logic [CW:0] step_up(input logic [CW-1:0] v);
    return {1'b0, v} + {{CW{1'b0}}, 1'b1};
  endfunction

  logic [CW:0] nxt;
  assign nxt      = step_up(cnt);
  assign wrap_evt = !ld_en && !reload && nxt[CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (ld_en)  cnt <= ld_val;
    else if (reload) cnt <= '0;
    else             cnt <= nxt[CW-1:0];
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> cnt == $past(ld_val));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !reload) |=> cnt == CW'($past(cnt) + 1'b1));
  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && reload) |=> cnt == '0);
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cnt == '0);
endmodule

// File: rtl/tmr_gr_slot.sv
module tmr_gr_slot
  import tmr_pkg::*;
#(
  parameter int unsigned CW   = 16,
  parameter bit          IS_A = 1'b0,
  parameter bit          IS_D = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          cmp_mode,
  input  logic          strobe,
  input  logic          xtrig,
  input  logic          pwm_en,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  output logic [CW-1:0] gr,
  output logic          set_evt,
  output logic          period_hit
);
  logic eff_cmp, match, cap_ext, cap_x;

  assign eff_cmp    = (cmp_mode == MODE_COMPARE) || (IS_D && pwm_en);
  assign match      = eff_cmp && (cnt == gr);
  assign cap_ext    = !eff_cmp && strobe;
  assign cap_x      = IS_D && !eff_cmp && xtrig;
  assign set_evt    = (match || cap_ext) && !(IS_A && pwm_en);
  assign period_hit = IS_D && pwm_en && match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gr <= '0;
    else if (cap_ext || cap_x) gr <= cnt;
    else if (wr_en)            gr <= wr_val;
  end

  a_r4_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ext |=> gr == $past(cnt));
  a_r6_compare_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_cmp && !wr_en) |=> $stable(gr));
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int unsigned NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_evt,
  input  logic          rd_stat,
  input  logic          wr_stat,
  input  logic [NF-1:0] wdata,
  output logic [NF-1:0] flags,
  output logic          irq
);
  logic [NF-1:0] seen, clr;

  assign clr = {NF{wr_stat}} & ~wdata & seen;
  assign irq = |flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      seen  <= '0;
    end else begin
      flags <= set_evt | (flags & ~clr);
      if (wr_stat)      seen <= '0;
      else if (rd_stat) seen <= flags;
    end
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt) |=> ((flags & $past(set_evt)) == $past(set_evt)));
  a_r7_unseen_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((flags & $past(flags & ~seen)) == $past(flags & ~seen)));
  a_r7_one_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((flags & $past(flags & wdata)) == $past(flags & wdata)));
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tmr_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned NGR = 4,
  parameter int unsigned AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_rd,
  input  logic           bus_wr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  input  logic [NGR-1:0] gr_cmp_mode,
  input  logic [NGR-1:0] cap_strobe,
  input  logic           xch_trig,
  input  logic           pwm_en,
  output logic           irq
);
  localparam int unsigned NF   = NGR + 1;
  localparam int unsigned ID_D = NGR - 1;

  logic [CW-1:0]  cnt;
  logic           wrap_evt;
  logic [CW-1:0]  gr_q [NGR];
  logic [NGR-1:0] gr_set, gr_period, gr_wr;
  logic [NF-1:0]  flags;
  logic           sel_stat, sel_cnt;

  assign sel_stat = (bus_addr == AW'(ADDR_STAT));
  assign sel_cnt  = (bus_addr == AW'(ADDR_CNT));

  tmr_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (bus_wr && sel_cnt),
    .ld_val   (bus_wdata),
    .reload   (gr_period[ID_D]),
    .cnt      (cnt),
    .wrap_evt (wrap_evt)
  );

  for (genvar i = 0; i < NGR; i++) begin : g_gr
    assign gr_wr[i] = bus_wr && (bus_addr == AW'(ADDR_GR0 + i));
    tmr_gr_slot #(
      .CW   (CW),
      .IS_A (i == 0),
      .IS_D (i == ID_D)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt        (cnt),
      .cmp_mode   (gr_cmp_mode[i]),
      .strobe     (cap_strobe[i]),
      .xtrig      (xch_trig),
      .pwm_en     (pwm_en),
      .wr_en      (gr_wr[i]),
      .wr_val     (bus_wdata),
      .gr         (gr_q[i]),
      .set_evt    (gr_set[i]),
      .period_hit (gr_period[i])
    );
  end

  tmr_status #(.NF(NF)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt ({wrap_evt, gr_set}),
    .rd_stat (bus_rd && sel_stat),
    .wr_stat (bus_wr && sel_stat),
    .wdata   (bus_wdata[NF-1:0]),
    .flags   (flags),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_stat)     bus_rdata = CW'(flags);
    else if (sel_cnt) bus_rdata = cnt;
    for (int i = 0; i < NGR; i++)
      if (bus_addr == AW'(ADDR_GR0 + i)) bus_rdata = gr_q[i];
  end

  a_r9_pwm_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !flags[0]) |=> !flags[0]);
  a_r11_xtrig_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (xch_trig && !cap_strobe[ID_D] && !gr_cmp_mode[ID_D] && !pwm_en && !flags[ID_D])
      |=> !flags[ID_D]);
  a_r3_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flags[NGR]);
endmodule

// File: tb/tb_tmr_flag_unit.sv
module tb_tmr_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16, NGR = 4, AW = 3;
  localparam logic [AW-1:0] A_STAT = 0, A_CNT = 1;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [CW-1:0] bus_wdata = '0, bus_rdata;
  logic [NGR-1:0] gr_cmp_mode = '0, cap_strobe = '0;
  logic xch_trig = 0, pwm_en = 0, irq;

  int total = 0, bad = 0;

  tmr_flag_unit #(.CW(CW), .NGR(NGR), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gr_cmp_mode(gr_cmp_mode),
    .cap_strobe(cap_strobe), .xch_trig(xch_trig), .pwm_en(pwm_en), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [CW-1:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [CW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; step(); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [CW-1:0] v);
    bus_addr = a; bus_rd = 1; #1; v = bus_rdata; step(); bus_rd = 0;
  endtask

  task automatic clear_all();
    logic [CW-1:0] v;
    bus_read(A_STAT, v);
    bus_write(A_STAT, '0);
  endtask

  function automatic logic [AW-1:0] gra(input int i);
    return AW'(2 + i);
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] v, base;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state, sampled before the first counting edge
    peek(A_CNT, v);  chk("R1 counter", v, 16'h0);
    peek(A_STAT, v); chk("R1 status", v, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    for (int i = 0; i < NGR; i++) begin peek(gra(i), v); chk("R1 gr", v, 16'h0); end
    step();

    // R2: load and count
    bus_write(A_CNT, 16'h1234);
    repeat (5) step();
    peek(A_CNT, v); chk("R2 count after load", v, 16'h1239);

    // R4: capture sweep over every register
    for (int i = 0; i < NGR; i++) begin
      base = 16'h0100 * (i + 1) + 16'h7; n = i + 2;
      bus_write(A_CNT, base);
      repeat (n) step();
      cap_strobe[i] = 1; step(); cap_strobe = '0;
      peek(gra(i), v); chk("R4 captured value", v, base + 16'(n));
      peek(A_STAT, v); chk("R4 flag", v, 16'(1 << i));
      chk("R12 irq set", {15'b0, irq}, 16'h1);
      bus_read(A_STAT, v);
      bus_write(A_STAT, 16'hFFFF & ~16'(1 << i));
      peek(A_STAT, v); chk("R7 cleared after read", v, 16'h0);
      chk("R12 irq clear", {15'b0, irq}, 16'h0);
    end

    // R5: compare sweep, timing of the flag
    for (int i = 0; i < NGR; i++) begin
      gr_cmp_mode = NGR'(1 << i);
      base = 16'h4000 + 16'h0100 * i; n = 3 + i;
      bus_write(gra(i), base + 16'(n));
      bus_write(A_CNT, base);
      repeat (n) step();
      peek(A_STAT, v); chk("R5 match cycle no flag yet", v, 16'h0);
      step();
      peek(A_STAT, v); chk("R5 flag after match", v, 16'(1 << i));
      gr_cmp_mode = '0;
      clear_all();
    end

    // R6: strobe ignored in compare mode
    gr_cmp_mode = 4'b0010;
    bus_write(gra(1), 16'hBEEF);
    cap_strobe[1] = 1; step(); cap_strobe = '0;
    peek(gra(1), v); chk("R6 register kept", v, 16'hBEEF);
    peek(A_STAT, v); chk("R6 no flag", v, 16'h0);
    gr_cmp_mode = '0;

    // R7: clearing handshake
    cap_strobe[2] = 1; step(); cap_strobe = '0;
    bus_write(A_STAT, 16'h0);
    peek(A_STAT, v); chk("R7 write0 without read", v, 16'h0004);
    bus_read(A_STAT, v);
    bus_write(A_STAT, 16'h0004);
    peek(A_STAT, v); chk("R7 write1 no effect", v, 16'h0004);
    bus_write(A_STAT, 16'h0);
    peek(A_STAT, v); chk("R7 read used up", v, 16'h0004);
    bus_read(A_STAT, v);
    bus_write(A_STAT, 16'h0);
    peek(A_STAT, v); chk("R7 proper clear", v, 16'h0);

    // R8: set and clear in the same cycle
    cap_strobe[0] = 1; step(); cap_strobe = '0;
    bus_read(A_STAT, v);
    bus_addr = A_STAT; bus_wdata = '0; bus_wr = 1; cap_strobe[0] = 1;
    step(); bus_wr = 0; cap_strobe = '0;
    peek(A_STAT, v); chk("R8 set wins", v, 16'h0001);
    clear_all();
    peek(A_STAT, v); chk("R8 later clear", v, 16'h0);

    // R3: overflow
    bus_write(A_CNT, 16'hFFFD);
    repeat (2) step();
    peek(A_STAT, v); chk("R3 no flag at FFFF", v, 16'h0);
    step();
    peek(A_STAT, v); chk("R3 overflow flag", v, 16'h0010);
    peek(A_CNT, v);  chk("R3 counter wrapped", v, 16'h0000);
    clear_all();

    // R9: register 0 flag suppressed in PWM mode
    bus_write(gra(3), 16'h0800);
    pwm_en = 1;
    bus_write(A_CNT, 16'h0);
    cap_strobe[0] = 1; step(); cap_strobe = '0;
    peek(A_STAT, v); chk("R9 capture no flag", v & 16'h1, 16'h0);
    gr_cmp_mode = 4'b0001;
    bus_write(gra(0), 16'h0100);
    bus_write(A_CNT, 16'h00F0);
    repeat (32) step();
    peek(A_STAT, v); chk("R9 compare no flag", v & 16'h1, 16'h0);
    pwm_en = 0; gr_cmp_mode = '0;
    clear_all();

    // R10: period register reload
    bus_write(gra(3), 16'h0050);
    clear_all();
    pwm_en = 1;
    bus_write(A_CNT, 16'h004D);
    repeat (3) step();
    peek(A_CNT, v);  chk("R10 counter at period", v, 16'h0050);
    peek(A_STAT, v); chk("R10 flag not yet", v, 16'h0);
    step();
    peek(A_CNT, v);  chk("R10 counter reloaded", v, 16'h0000);
    peek(A_STAT, v); chk("R10 period flag", v, 16'h0008);
    repeat (2) step();
    peek(A_CNT, v);  chk("R10 counting resumed", v, 16'h0002);
    pwm_en = 0;
    clear_all();

    // R11: cross-channel trigger copies without flag
    base = 16'h2000;
    bus_write(A_CNT, base);
    repeat (4) step();
    xch_trig = 1; step(); xch_trig = 0;
    peek(gra(3), v); chk("R11 copied value", v, base + 16'd4);
    peek(A_STAT, v); chk("R11 no flag", v, 16'h0);
    chk("R12 irq low", {15'b0, irq}, 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule